// File: doc/BRIEF.md
# Flag-Framed Ring Symbol Framer

This block sits between a packet-oriented client and a ring link that moves one 16-bit symbol per clock together with a single framing flag. Packets on the ring carry no length field and no delimiter symbols. A receiver finds where a packet starts from a rising edge of the flag. It finds where the packet ends from the point where the flag falls, counted back from the final symbol, and that distance depends on the packet kind.

The transmit half accepts a contiguous burst of symbols marked with start, end and an echo/ordinary kind, and drives the flag. It holds the burst in a short delay line so that it can lower the flag early enough before the end is reached. It refuses a packet too short to carry its kind's flag pattern. The receive half watches the flag, rebuilds start and end markers, reads the kind from the second symbol, and reports broken framing. Each packet is header, payload and a closing check symbol, which the block carries through without looking at it.

Top module: `flag_link_framer`

## Requirements
- R1: After reset, and on every link cycle that carries no symbol, `link_tx_valid`, `link_tx_flag` and `link_tx_sym` are all zero, and `rx_valid`, `rx_err` and `tx_err` are zero while nothing is sent.
- R2: The transmitter sends every accepted packet as an unbroken run of symbols in input order, with the flag at 1 on the first symbol.
- R3: For an ordinary (non-echo, `tx_echo`=0) packet the flag is 0 on exactly the final four symbols and 1 on every earlier symbol.
- R4: For an echo packet (`tx_echo`=1) the flag is 0 on the final symbol only.
- R5: An ordinary packet of fewer than five symbols, or an echo packet of one symbol, is not sent at all, and `tx_err` pulses high for one cycle.
- R6: The receiver starts a packet (`rx_sop`) only on a valid link symbol whose flag is 1 when the flag of the previous valid link symbol was 0.
- R7: The receiver takes the packet kind from bit 15 of the second symbol of a packet (1 = echo) and reports it on `rx_echo` together with `rx_eop`.
- R8: The receiver marks `rx_eop` on the final symbol: the symbol where the flag falls for an echo packet, and the third symbol after the fall for an ordinary packet.
- R9: A cycle without a valid link symbol inside a packet raises `rx_err` for one cycle, and the remaining symbols of that packet are discarded.
- R10: A flag that rises again after it fell, before the packet has ended, raises `rx_err`, and that symbol and the rest of the packet are discarded.
- R11: Each received symbol appears on the `rx_*` outputs one clock after it was present on the link inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Client symbol present |
| tx_data | input | 16 | Client symbol |
| tx_sop | input | 1 | First symbol of a packet |
| tx_eop | input | 1 | Last symbol of a packet |
| tx_echo | input | 1 | Packet kind, sampled with `tx_sop` |
| tx_err | output | 1 | Packet refused as too short |
| link_tx_valid | output | 1 | Symbol on outgoing link |
| link_tx_flag | output | 1 | Outgoing framing flag |
| link_tx_sym | output | 16 | Outgoing symbol |
| link_rx_valid | input | 1 | Symbol on incoming link |
| link_rx_flag | input | 1 | Incoming framing flag |
| link_rx_sym | input | 16 | Incoming symbol |
| rx_valid | output | 1 | Received symbol present |
| rx_data | output | 16 | Received symbol |
| rx_sop | output | 1 | First symbol of a received packet |
| rx_eop | output | 1 | Last symbol of a received packet |
| rx_echo | output | 1 | Kind of the ending packet, valid with `rx_eop` |
| rx_err | output | 1 | Framing error pulse |

## Verification
The hardest states to reach are broken framings on the receive side: a hole in the middle of a packet, and a flag that rises again inside the tail. A well-behaved transmitter never produces either. The bench therefore switches the receiver's link inputs away from the loopback path and drives raw symbol and flag sequences itself. It inserts an idle cycle or forces the flag high at a chosen symbol index. It then sends a clean packet to show that the receiver resynchronises afterwards.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HEAD = 2'd1,
    RX_TAIL = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rsf_rst_sync.sv
module rsf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/rsf_tx_framer.sv
module rsf_tx_framer #(
  parameter int SYM_W     = 16,
  parameter int ECHO_TAIL = 1,
  parameter int DATA_TAIL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             in_echo,
  output logic             err,
  output logic             out_valid,
  output logic             out_flag,
  output logic [SYM_W-1:0] out_sym
);
  localparam int DEPTH = DATA_TAIL;
  localparam int CNT_W = $clog2(DATA_TAIL + 1);

  logic [DEPTH-1:0] st_vld_q, st_vld_d;
  logic [DEPTH-1:0] st_flg_q, st_flg_d;
  logic [SYM_W-1:0] st_sym_q [DEPTH];
  logic             in_pkt_q, in_pkt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             kind_q;
  logic             err_q;

  logic             accept;
  logic [CNT_W-1:0] pos;
  logic             kind;
  logic [CNT_W-1:0] tail_len;
  logic             is_last;
  logic             too_short;
  logic             finish;
  logic             kind_en;

  // next-state: acceptance, position and kind of the incoming symbol
  always_comb begin
    accept    = in_valid && (in_sop || in_pkt_q);
    pos       = in_sop ? '0 : cnt_q;
    kind      = in_sop ? in_echo : kind_q;
    tail_len  = kind ? CNT_W'(ECHO_TAIL) : CNT_W'(DATA_TAIL);
    is_last   = accept && in_eop;
    too_short = is_last && (pos < tail_len);
    finish    = is_last && !too_short;
    kind_en   = accept && in_sop;

    in_pkt_d = in_pkt_q;
    cnt_d    = cnt_q;
    if (accept) begin
      in_pkt_d = !in_eop;
      if (in_eop)                         cnt_d = '0;
      else if (pos == CNT_W'(DATA_TAIL))  cnt_d = pos;
      else                                cnt_d = pos + 1'b1;
    end
  end

  // next-state: delay line, with tail flags cleared once the end is seen
  always_comb begin
    st_vld_d[0] = accept && !too_short;
    st_flg_d[0] = !in_eop;
    for (int i = 1; i < DEPTH; i++) begin
      st_vld_d[i] = st_vld_q[i-1] && !(too_short && ((i - 1) < int'(pos)));
      st_flg_d[i] = st_flg_q[i-1] && !(finish && ((i - 1) < (int'(tail_len) - 1)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vld_q <= '0;
      st_flg_q <= '0;
      in_pkt_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_vld_q <= st_vld_d;
      st_flg_q <= st_flg_d;
      in_pkt_q <= in_pkt_d;
      cnt_q    <= cnt_d;
      err_q    <= too_short;
      if (kind_en) kind_q <= in_echo;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_sym_q[g] <= '0;
        end else begin
          if (g == 0) st_sym_q[g] <= in_data;
          else        st_sym_q[g] <= st_sym_q[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign out_valid = st_vld_q[DEPTH-1];
  assign out_flag  = st_vld_q[DEPTH-1] && st_flg_q[DEPTH-1];
  assign out_sym   = st_vld_q[DEPTH-1] ? st_sym_q[DEPTH-1] : '0;
  assign err       = err_q;
endmodule

// File: rtl/rsf_rx_deframer.sv
module rsf_rx_deframer
  import rsf_pkg::*;
#(
  parameter int SYM_W     = 16,
  parameter int KIND_BIT  = 15,
  parameter int ECHO_TAIL = 1,
  parameter int DATA_TAIL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_flag,
  input  logic [SYM_W-1:0] lk_sym,
  output logic             o_valid,
  output logic [SYM_W-1:0] o_data,
  output logic             o_sop,
  output logic             o_eop,
  output logic             o_echo,
  output logic             o_err,
  output logic             busy
);
  localparam int CNT_W = $clog2(DATA_TAIL + 1);

  rx_state_e        state_q, state_d;
  logic             prev_flg_q, prev_flg_d;
  logic             second_q, second_d;
  logic             kind_q, kind_d;
  logic [CNT_W-1:0] tail_q, tail_d;

  logic             v_d, sop_d, eop_d, echo_d, err_d;
  logic             o_valid_q, o_sop_q, o_eop_q, o_echo_q, o_err_q;
  logic [SYM_W-1:0] o_data_q;

  logic             rise;
  logic             kind_now;
  logic [CNT_W-1:0] len_now;

  always_comb begin
    rise     = lk_valid && lk_flag && !prev_flg_q;
    kind_now = second_q ? lk_sym[KIND_BIT] : kind_q;
    len_now  = kind_now ? CNT_W'(ECHO_TAIL) : CNT_W'(DATA_TAIL);

    state_d    = state_q;
    prev_flg_d = lk_valid ? lk_flag : prev_flg_q;
    second_d   = second_q;
    kind_d     = kind_q;
    tail_d     = tail_q;
    v_d        = 1'b0;
    sop_d      = 1'b0;
    eop_d      = 1'b0;
    echo_d     = 1'b0;
    err_d      = 1'b0;

    unique case (state_q)
      RX_IDLE: begin
        if (rise) begin
          v_d      = 1'b1;
          sop_d    = 1'b1;
          second_d = 1'b1;
          state_d  = RX_HEAD;
        end
      end
      RX_HEAD: begin
        if (!lk_valid) begin
          err_d   = 1'b1;
          state_d = RX_IDLE;
        end else begin
          v_d      = 1'b1;
          second_d = 1'b0;
          kind_d   = kind_now;
          if (!lk_flag) begin
            if (len_now == CNT_W'(1)) begin
              eop_d   = 1'b1;
              echo_d  = kind_now;
              state_d = RX_IDLE;
            end else begin
              tail_d  = len_now - 1'b1;
              state_d = RX_TAIL;
            end
          end
        end
      end
      RX_TAIL: begin
        if (!lk_valid || lk_flag) begin
          err_d   = 1'b1;
          state_d = RX_IDLE;
        end else begin
          v_d = 1'b1;
          if (tail_q == CNT_W'(1)) begin
            eop_d   = 1'b1;
            echo_d  = kind_q;
            state_d = RX_IDLE;
          end else begin
            tail_d = tail_q - 1'b1;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      prev_flg_q <= 1'b0;
      second_q   <= 1'b0;
      kind_q     <= 1'b0;
      tail_q     <= '0;
      o_valid_q  <= 1'b0;
      o_sop_q    <= 1'b0;
      o_eop_q    <= 1'b0;
      o_echo_q   <= 1'b0;
      o_err_q    <= 1'b0;
      o_data_q   <= '0;
    end else begin
      state_q    <= state_d;
      prev_flg_q <= prev_flg_d;
      second_q   <= second_d;
      kind_q     <= kind_d;
      tail_q     <= tail_d;
      o_valid_q  <= v_d;
      o_sop_q    <= sop_d;
      o_eop_q    <= eop_d;
      o_echo_q   <= echo_d;
      o_err_q    <= err_d;
      o_data_q   <= v_d ? lk_sym : '0;
    end
  end

  assign o_valid = o_valid_q;
  assign o_data  = o_data_q;
  assign o_sop   = o_sop_q;
  assign o_eop   = o_eop_q;
  assign o_echo  = o_echo_q;
  assign o_err   = o_err_q;
  assign busy    = (state_q != RX_IDLE);
endmodule

// File: rtl/flag_link_framer.sv
module flag_link_framer #(
  parameter int SYM_W     = 16,
  parameter int KIND_BIT  = 15,
  parameter int ECHO_TAIL = 1,
  parameter int DATA_TAIL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [SYM_W-1:0] tx_data,
  input  logic             tx_sop,
  input  logic             tx_eop,
  input  logic             tx_echo,
  output logic             tx_err,
  output logic             link_tx_valid,
  output logic             link_tx_flag,
  output logic [SYM_W-1:0] link_tx_sym,
  input  logic             link_rx_valid,
  input  logic             link_rx_flag,
  input  logic [SYM_W-1:0] link_rx_sym,
  output logic             rx_valid,
  output logic [SYM_W-1:0] rx_data,
  output logic             rx_sop,
  output logic             rx_eop,
  output logic             rx_echo,
  output logic             rx_err
);
  logic rst_n_s;
  logic rx_busy;

  rsf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rsf_tx_framer #(
    .SYM_W     (SYM_W),
    .ECHO_TAIL (ECHO_TAIL),
    .DATA_TAIL (DATA_TAIL)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_valid  (tx_valid),
    .in_data   (tx_data),
    .in_sop    (tx_sop),
    .in_eop    (tx_eop),
    .in_echo   (tx_echo),
    .err       (tx_err),
    .out_valid (link_tx_valid),
    .out_flag  (link_tx_flag),
    .out_sym   (link_tx_sym)
  );

  rsf_rx_deframer #(
    .SYM_W     (SYM_W),
    .KIND_BIT  (KIND_BIT),
    .ECHO_TAIL (ECHO_TAIL),
    .DATA_TAIL (DATA_TAIL)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lk_valid (link_rx_valid),
    .lk_flag  (link_rx_flag),
    .lk_sym   (link_rx_sym),
    .o_valid  (rx_valid),
    .o_data   (rx_data),
    .o_sop    (rx_sop),
    .o_eop    (rx_eop),
    .o_echo   (rx_echo),
    .o_err    (rx_err),
    .busy     (rx_busy)
  );
endmodule

// File: rtl/rsf_checker.sv
module rsf_checker (
  input logic clk,
  input logic rst_n_s,
  input logic tx_valid,
  input logic tx_eop,
  input logic tx_err,
  input logic link_tx_valid,
  input logic link_tx_flag,
  input logic link_rx_valid,
  input logic link_rx_flag,
  input logic rx_valid,
  input logic rx_sop,
  input logic rx_eop,
  input logic rx_echo,
  input logic rx_err,
  input logic rx_busy
);
  AST_TX_FLAG_QUAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    link_tx_flag |-> link_tx_valid); // R1
  AST_TX_SHORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_err |-> $past(tx_valid && tx_eop)); // R5
  AST_RX_SOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_sop |-> $past(link_rx_valid && link_rx_flag)); // R6
  AST_RX_ECHO_QUAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_echo |-> rx_eop); // R7
  AST_RX_EOP_QUAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_eop |-> rx_valid); // R8
  AST_RX_GAP_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_busy && !link_rx_valid) |=> rx_err); // R9
  AST_RX_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_err |-> !rx_valid); // R10
endmodule

bind flag_link_framer rsf_checker u_chk (
  .clk           (clk),
  .rst_n_s       (rst_n_s),
  .tx_valid      (tx_valid),
  .tx_eop        (tx_eop),
  .tx_err        (tx_err),
  .link_tx_valid (link_tx_valid),
  .link_tx_flag  (link_tx_flag),
  .link_rx_valid (link_rx_valid),
  .link_rx_flag  (link_rx_flag),
  .rx_valid      (rx_valid),
  .rx_sop        (rx_sop),
  .rx_eop        (rx_eop),
  .rx_echo       (rx_echo),
  .rx_err        (rx_err),
  .rx_busy       (rx_busy)
);

// File: tb/tb_flag_link_framer.sv
module tb_flag_link_framer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_valid, tx_sop, tx_eop, tx_echo;
  logic [15:0] tx_data;
  logic        tx_err;
  logic        link_tx_valid, link_tx_flag;
  logic [15:0] link_tx_sym;
  logic        link_rx_valid, link_rx_flag;
  logic [15:0] link_rx_sym;
  logic        rx_valid, rx_sop, rx_eop, rx_echo, rx_err;
  logic [15:0] rx_data;

  logic        lb;
  logic        d_valid, d_flag;
  logic [15:0] d_sym;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  logic [15:0] txl_sym [64];
  logic        txl_flg [64];
  int          txl_t   [64];
  int          txl_n;
  int          tx_errs;
  logic [15:0] rxl_sym [64];
  logic        rxl_sop [64];
  logic        rxl_eop [64];
  logic        rxl_echo[64];
  int          rxl_t   [64];
  int          rxl_n;
  int          rx_errs;

  always #10 clk = ~clk;

  assign link_rx_valid = lb ? link_tx_valid : d_valid;
  assign link_rx_flag  = lb ? link_tx_flag  : d_flag;
  assign link_rx_sym   = lb ? link_tx_sym   : d_sym;

  flag_link_framer dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_echo(tx_echo), .tx_err(tx_err),
    .link_tx_valid(link_tx_valid), .link_tx_flag(link_tx_flag), .link_tx_sym(link_tx_sym),
    .link_rx_valid(link_rx_valid), .link_rx_flag(link_rx_flag), .link_rx_sym(link_rx_sym),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_echo(rx_echo), .rx_err(rx_err)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (link_tx_valid && txl_n < 64) begin
      txl_sym[txl_n] = link_tx_sym;
      txl_flg[txl_n] = link_tx_flag;
      txl_t[txl_n]   = cyc;
      txl_n = txl_n + 1;
    end
    if (tx_err) tx_errs = tx_errs + 1;
    if (rx_valid && rxl_n < 64) begin
      rxl_sym[rxl_n]  = rx_data;
      rxl_sop[rxl_n]  = rx_sop;
      rxl_eop[rxl_n]  = rx_eop;
      rxl_echo[rxl_n] = rx_echo;
      rxl_t[rxl_n]    = cyc;
      rxl_n = rxl_n + 1;
    end
    if (rx_err) rx_errs = rx_errs + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      miscompares = miscompares + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] psym(input int base, input int i, input bit echo);
    logic [15:0] s;
    s = 16'(base + i);
    if (i == 1) s[15] = echo;
    return s;
  endfunction

  task automatic clear_logs();
    txl_n = 0; rxl_n = 0; tx_errs = 0; rx_errs = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic send_tx(input int len, input bit echo, input int base);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      tx_valid = 1'b1; tx_data = psym(base, i, echo);
      tx_sop = (i == 0); tx_eop = (i == len - 1); tx_echo = echo;
    end
    @(posedge clk); #1;
    tx_valid = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0; tx_echo = 1'b0; tx_data = '0;
  endtask

  // drives the link directly; gap_at inserts one idle cycle before that index,
  // rise_at forces the flag to 1 at that index; returns cyc at first drive
  task automatic send_link(input int len, input bit echo, input int base,
                           input int gap_at, input int rise_at, output int t0);
    int tail;
    tail = echo ? 1 : 4;
    t0 = 0;
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) begin
        @(posedge clk); #1;
        d_valid = 1'b0; d_flag = 1'b0; d_sym = '0;
      end
      @(posedge clk); #1;
      if (i == 0) t0 = cyc;
      d_valid = 1'b1; d_sym = psym(base, i, echo);
      d_flag = (i < len - tail) || (i == rise_at);
    end
    @(posedge clk); #1;
    d_valid = 1'b0; d_flag = 1'b0; d_sym = '0;
  endtask

  task automatic expect_tx(input int len, input bit echo, input int base, input string tag);
    int tail;
    tail = echo ? 1 : 4;
    check(txl_n == len, {tag, " tx symbol count"}, txl_n, len);
    for (int i = 0; i < len && i < txl_n; i++) begin
      check(txl_sym[i] == psym(base, i, echo), {tag, " tx symbol"}, txl_sym[i], psym(base, i, echo));
      check(txl_flg[i] == (i < len - tail), {tag, " tx flag"}, txl_flg[i], (i < len - tail));
      check(txl_t[i] == txl_t[0] + i, {"R2 tx contiguous"}, txl_t[i], txl_t[0] + i);
    end
  endtask

  task automatic expect_rx(input int first, input int len, input bit echo, input int base, input string tag);
    check(rxl_n >= first + len, {tag, " rx symbol count"}, rxl_n, first + len);
    for (int i = 0; i < len && first + i < rxl_n; i++) begin
      check(rxl_sym[first+i] == psym(base, i, echo), {tag, " rx symbol"}, rxl_sym[first+i], psym(base, i, echo));
      check(rxl_sop[first+i] == (i == 0), {"R6 rx sop"}, rxl_sop[first+i], (i == 0));
      check(rxl_eop[first+i] == (i == len - 1), {"R8 rx eop"}, rxl_eop[first+i], (i == len - 1));
      if (i == len - 1)
        check(rxl_echo[first+i] == echo, {"R7 rx kind"}, rxl_echo[first+i], echo);
    end
  endtask

  task automatic t_reset();
    check(link_tx_valid == 0 && link_tx_flag == 0 && link_tx_sym == 0, "R1 link idle after reset",
          {link_tx_valid, link_tx_flag, link_tx_sym}, 0);
    check(rx_valid == 0 && rx_err == 0 && tx_err == 0, "R1 outputs idle after reset",
          {rx_valid, rx_err, tx_err}, 0);
    clear_logs(); idle(6);
    check(txl_n == 0 && rxl_n == 0, "R1 nothing sent while idle", txl_n + rxl_n, 0);
  endtask

  task automatic t_tx_ordinary();
    lb = 1'b1; clear_logs();
    send_tx(6, 1'b0, 16'h0100); idle(10);
    expect_tx(6, 1'b0, 16'h0100, "R3");
    check(txl_n > 0 && txl_flg[0] == 1'b1, "R2 flag high on first symbol", txl_n > 0 ? txl_flg[0] : 0, 1);
    expect_rx(0, 6, 1'b0, 16'h0100, "R8 loopback ordinary");
    check(tx_errs == 0 && rx_errs == 0, "R5 no error on valid packet", tx_errs + rx_errs, 0);
    check(link_tx_sym == 0 && link_tx_flag == 0, "R1 link idle between packets", link_tx_sym, 0);
  endtask

  task automatic t_tx_echo();
    lb = 1'b1; clear_logs();
    send_tx(3, 1'b1, 16'h0200); idle(10);
    expect_tx(3, 1'b1, 16'h0200, "R4");
    expect_rx(0, 3, 1'b1, 16'h0200, "R7 loopback echo");
    clear_logs();
    send_tx(2, 1'b1, 16'h0300); idle(10);
    expect_tx(2, 1'b1, 16'h0300, "R4 shortest echo");
    expect_rx(0, 2, 1'b1, 16'h0300, "R8 shortest echo");
  endtask

  task automatic t_tx_bounds();
    lb = 1'b1; clear_logs();
    send_tx(5, 1'b0, 16'h0400); idle(10);
    expect_tx(5, 1'b0, 16'h0400, "R5 five-symbol ordinary accepted");
    check(tx_errs == 0, "R5 no error at five symbols", tx_errs, 0);
    clear_logs();
    send_tx(4, 1'b0, 16'h0500); idle(10);
    check(txl_n == 0, "R5 four-symbol ordinary not sent", txl_n, 0);
    check(tx_errs == 1, "R5 error pulse for short ordinary", tx_errs, 1);
    clear_logs();
    send_tx(1, 1'b1, 16'h0600); idle(10);
    check(txl_n == 0, "R5 one-symbol echo not sent", txl_n, 0);
    check(tx_errs == 1, "R5 error pulse for short echo", tx_errs, 1);
    check(rxl_n == 0, "R5 nothing reaches receiver", rxl_n, 0);
  endtask

  task automatic t_rx_back_to_back();
    int t0, t1;
    lb = 1'b0; clear_logs();
    send_link(7, 1'b0, 16'h0700, -1, -1, t0);
    check(rxl_n > 0 && rxl_t[0] == t0 + 2, "R11 one clock receive delay",
          rxl_n > 0 ? rxl_t[0] : 0, t0 + 2);
    send_link(2, 1'b1, 16'h0800, -1, -1, t1);
    idle(4);
    expect_rx(0, 7, 1'b0, 16'h0700, "R8 back-to-back first");
    expect_rx(7, 2, 1'b1, 16'h0800, "R6 back-to-back second");
    check(rx_errs == 0, "R6 no error on clean stream", rx_errs, 0);
  endtask

  task automatic t_rx_gap();
    int t0;
    lb = 1'b0; clear_logs();
    send_link(8, 1'b0, 16'h0900, 3, -1, t0); idle(4);
    check(rx_errs == 1, "R9 gap raises error", rx_errs, 1);
    check(rxl_n == 3, "R9 rest of packet dropped", rxl_n, 3);
    check(rxl_n == 3 && rxl_eop[2] == 1'b0, "R9 no end marker", rxl_n == 3 ? rxl_eop[2] : 1, 0);
    clear_logs();
    send_link(5, 1'b0, 16'h0A00, -1, -1, t0); idle(4);
    expect_rx(0, 5, 1'b0, 16'h0A00, "R9 recovery after gap");
  endtask

  task automatic t_rx_rerise();
    int t0;
    lb = 1'b0; clear_logs();
    send_link(6, 1'b0, 16'h0B00, -1, 3, t0); idle(4);
    check(rx_errs == 1, "R10 second rise raises error", rx_errs, 1);
    check(rxl_n == 3, "R10 rest of packet dropped", rxl_n, 3);
    clear_logs();
    send_link(3, 1'b1, 16'h0C00, -1, -1, t0); idle(4);
    expect_rx(0, 3, 1'b1, 16'h0C00, "R10 recovery after second rise");
  endtask

  initial begin
    #(200000 * 20);
    miscompares = miscompares + 1;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lb = 1'b1;
    tx_valid = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0; tx_echo = 1'b0; tx_data = '0;
    d_valid = 1'b0; d_flag = 1'b0; d_sym = '0;
    clear_logs();
    idle(3); #1;
    rst_n = 1'b1;
    idle(4); #1;
    t_reset();
    t_tx_ordinary();
    t_tx_echo();
    t_tx_bounds();
    t_rx_back_to_back();
    t_rx_gap();
    t_rx_rerise();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule